// File: doc/BRIEF.md
# Subroutine Call/Return Sequencer

This block sequences the stack traffic for subroutine calls and returns in a small CPU with 16-bit addresses. It holds the program counter, the stack pointer and the condition-code register. A decoded request names one of five operations: a call whose target comes from a register, from a 16-bit absolute address, or from a word read at an 8-bit vector address; a plain return; or a return from exception. The block then runs that operation's memory accesses on a byte-wide synchronous memory port, one state per clock. Each operation has a fixed number of states.

Stack words are stored big-endian: the high byte is at the even address and the low byte at the next one. The surrounding core raises `reqValid` with the operands for one cycle. It watches `busy`, and treats the single-cycle `done` pulse as the end of the operation.

Top module: `subr_seq`

## Requirements
- R1: While reset is low and after it is released, `pc` equals RESET_PC (default 0x0100), `sp` equals RESET_SP (default 0x0200), `ccr` equals RESET_CCR (default 0x80), and `busy`, `done` and `memWe` are low.
- R2: Every call first lowers `sp` by 2. It then writes the PC held before the call to the new stack pointer, high byte at address `sp` and low byte at `sp`+1. Writes happen only while `busy` is high.
- R3: A register call (reqOp code 0) loads `pc` from `reqReg` and takes 6 states.
- R4: An absolute call (reqOp code 1) loads `pc` from `reqAbs` and takes 8 states.
- R5: A vectored call (reqOp code 2) zero-extends `reqAbs[7:0]` to 16 bits to form address V. It loads `pc` with the word whose high byte is at V and low byte at V+1, so vector 0xFF reads 0x00FF and 0x0100. Read data arrives one cycle after the address. The call takes 8 states.
- R6: A return (reqOp code 3) loads `pc` from the big-endian word at `sp`, raises `sp` by 2 and takes 8 states.
- R7: A return from exception (reqOp code 4) first pops a word and loads `ccr` with its low byte, raising `sp` by 2. It then pops the next word into `pc` and raises `sp` by 2 again, for 10 states in total.
- R8: Calls and plain returns leave `ccr` unchanged.
- R9: An operation of N states keeps `busy` high for the N cycles after the accepting edge. `done` is high in the last of them only. `pc` takes its new value at the edge that ends the `done` cycle, and `busy` then falls.
- R10: A request presented while `busy` is high is ignored and is not held for later.
- R11: A request with reqOp codes 5 to 7 is ignored and leaves `busy`, `pc`, `sp` and `ccr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, sampled when not busy |
| reqOp | input | 3 | Operation code (0..4) |
| reqReg | input | 16 | Register-form call target |
| reqAbs | input | 16 | Absolute target, or vector in bits 7:0 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last state of the operation |
| memAddr | output | 16 | Memory byte address |
| memWdata | output | 8 | Memory write byte |
| memWe | output | 1 | Memory write enable |
| memRdata | input | 8 | Read byte, valid one cycle after its address |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| ccr | output | 8 | Condition-code register |

## Verification
The checker assumes that the memory returns read data exactly one cycle after the address and that operation codes above 4 carry no meaning. It also assumes that the block alone moves the stack pointer, so every change of `sp` is a step of two. The bench models a memory with that one-cycle read latency and preloads vectors and stack words through a separate port of its own. It changes requests only on the falling edge, and it sends mid-operation and undefined-code requests on purpose to probe the ignore rules.

// File: rtl/subr_pkg.sv
package subr_pkg;

  typedef enum logic [2:0] {
    OP_CALL_REG = 3'd0,
    OP_CALL_ABS = 3'd1,
    OP_CALL_IND = 3'd2,
    OP_RET      = 3'd3,
    OP_RETX     = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    ADR_SP   = 2'd0,
    ADR_SP1  = 2'd1,
    ADR_VEC  = 2'd2,
    ADR_VEC1 = 2'd3
  } adrSel_e;

  typedef enum logic [1:0] {
    PC_KEEP = 2'd0,
    PC_REG  = 2'd1,
    PC_ABS  = 2'd2,
    PC_TMP  = 2'd3
  } pcSel_e;

  typedef struct packed {
    logic    latch;
    logic    spDec;
    logic    spInc;
    logic    memWe;
    logic    wrHi;
    adrSel_e adrSel;
    logic    capHi;
    logic    capLo;
    logic    ccrLoad;
    pcSel_e  pcSel;
  } strobes_t;

  localparam int unsigned STATES_CALL_REG = 6;
  localparam int unsigned STATES_CALL_ABS = 8;
  localparam int unsigned STATES_CALL_IND = 8;
  localparam int unsigned STATES_RET      = 8;
  localparam int unsigned STATES_RETX     = 10;
  localparam int unsigned STATES_MAX      = 10;
  localparam int unsigned STEP_W          = $clog2(STATES_MAX);
  localparam logic [2:0]  OP_LAST_CODE    = 3'd4;

  function automatic int unsigned stateCount(op_e op);
    case (op)
      OP_CALL_REG: return STATES_CALL_REG;
      OP_CALL_ABS: return STATES_CALL_ABS;
      OP_CALL_IND: return STATES_CALL_IND;
      OP_RET:      return STATES_RET;
      default:     return STATES_RETX;
    endcase
  endfunction

endpackage

// File: rtl/subr_ctrl.sv
module subr_ctrl
  import subr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqOp,
  output logic       busy,
  output logic       done,
  output strobes_t   stb
);

  op_e               opQ;
  logic [STEP_W-1:0] step;
  logic              accept;
  logic              lastStep;
  logic [STEP_W-1:0] lastIdx;

  assign accept   = reqValid && !busy && (reqOp <= OP_LAST_CODE);
  assign lastIdx  = STEP_W'(stateCount(opQ) - 1);
  assign lastStep = (step == lastIdx);
  assign done     = busy && lastStep;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      step <= '0;
      opQ  <= OP_CALL_REG;
    end else if (!busy) begin
      if (accept) begin
        busy <= 1'b1;
        step <= '0;
        opQ  <= op_e'(reqOp);
      end
    end else if (lastStep) begin
      busy <= 1'b0;
      step <= '0;
    end else begin
      step <= step + 1'b1;
    end
  end

  // Push of the return address, shared by all call forms.
  function automatic void pushStep(input logic [STEP_W-1:0] s, inout strobes_t t);
    case (s)
      STEP_W'(0): t.spDec = 1'b1;
      STEP_W'(1): begin t.memWe = 1'b1; t.wrHi = 1'b1; t.adrSel = ADR_SP;  end
      STEP_W'(2): begin t.memWe = 1'b1; t.wrHi = 1'b0; t.adrSel = ADR_SP1; end
      default: ;
    endcase
  endfunction

  // Big-endian word read starting at step base.
  function automatic void popStep(input logic [STEP_W-1:0] s, input logic [STEP_W-1:0] base,
                                  input adrSel_e a0, input adrSel_e a1, inout strobes_t t);
    if (s == base) t.adrSel = a0;
    if (s == base + STEP_W'(1)) begin t.adrSel = a1; t.capHi = 1'b1; end
    if (s == base + STEP_W'(2)) t.capLo = 1'b1;
  endfunction

  always_comb begin
    stb       = '0;
    stb.latch = accept;
    if (busy) begin
      case (opQ)
        OP_CALL_REG: begin
          pushStep(step, stb);
          if (lastStep) stb.pcSel = PC_REG;
        end
        OP_CALL_ABS: begin
          pushStep(step, stb);
          if (lastStep) stb.pcSel = PC_ABS;
        end
        OP_CALL_IND: begin
          pushStep(step, stb);
          popStep(step, STEP_W'(3), ADR_VEC, ADR_VEC1, stb);
          if (lastStep) stb.pcSel = PC_TMP;
        end
        OP_RET: begin
          popStep(step, STEP_W'(0), ADR_SP, ADR_SP1, stb);
          if (step == STEP_W'(3)) stb.spInc = 1'b1;
          if (lastStep) stb.pcSel = PC_TMP;
        end
        default: begin
          popStep(step, STEP_W'(0), ADR_SP, ADR_SP1, stb);
          if (step == STEP_W'(3)) begin stb.ccrLoad = 1'b1; stb.spInc = 1'b1; end
          popStep(step, STEP_W'(4), ADR_SP, ADR_SP1, stb);
          if (step == STEP_W'(7)) stb.spInc = 1'b1;
          if (lastStep) stb.pcSel = PC_TMP;
        end
      endcase
    end
  end

endmodule

// File: rtl/subr_dpath.sv
module subr_dpath
  import subr_pkg::*;
#(
  parameter int         ADDR_W    = 16,
  parameter int         BYTE_W    = 8,
  parameter logic [15:0] RESET_PC  = 16'h0100,
  parameter logic [15:0] RESET_SP  = 16'h0200,
  parameter logic [7:0]  RESET_CCR = 8'h80
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [ADDR_W-1:0] reqReg,
  input  logic [ADDR_W-1:0] reqAbs,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  output logic              memWe,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp,
  output logic [BYTE_W-1:0] ccr
);

  localparam int VEC_W = 8;

  logic [ADDR_W-1:0] regQ;
  logic [ADDR_W-1:0] absQ;
  logic [BYTE_W-1:0] tmpHi;
  logic [BYTE_W-1:0] tmpLo;
  logic [ADDR_W-1:0] vecAddr;

  assign vecAddr = {{(ADDR_W-VEC_W){1'b0}}, absQ[VEC_W-1:0]};

  always_comb begin
    case (stb.adrSel)
      ADR_SP:   memAddr = sp;
      ADR_SP1:  memAddr = sp + ADDR_W'(1);
      ADR_VEC:  memAddr = vecAddr;
      default:  memAddr = vecAddr + ADDR_W'(1);
    endcase
  end

  assign memWdata = stb.wrHi ? pc[ADDR_W-1 -: BYTE_W] : pc[BYTE_W-1:0];
  assign memWe    = stb.memWe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regQ  <= '0;
      absQ  <= '0;
      tmpHi <= '0;
      tmpLo <= '0;
      pc    <= RESET_PC;
      sp    <= RESET_SP;
      ccr   <= RESET_CCR;
    end else begin
      if (stb.latch) begin
        regQ <= reqReg;
        absQ <= reqAbs;
      end
      if (stb.capHi)   tmpHi <= memRdata;
      if (stb.capLo)   tmpLo <= memRdata;
      if (stb.spDec)   sp    <= sp - ADDR_W'(2);
      if (stb.spInc)   sp    <= sp + ADDR_W'(2);
      if (stb.ccrLoad) ccr   <= tmpLo;
      case (stb.pcSel)
        PC_REG:  pc <= regQ;
        PC_ABS:  pc <= absQ;
        PC_TMP:  pc <= {tmpHi, tmpLo};
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/subr_seq.sv
module subr_seq
  import subr_pkg::*;
#(
  parameter logic [15:0] RESET_PC  = 16'h0100,
  parameter logic [15:0] RESET_SP  = 16'h0200,
  parameter logic [7:0]  RESET_CCR = 8'h80
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [2:0]  reqOp,
  input  logic [15:0] reqReg,
  input  logic [15:0] reqAbs,
  output logic        busy,
  output logic        done,
  output logic [15:0] memAddr,
  output logic [7:0]  memWdata,
  output logic        memWe,
  input  logic [7:0]  memRdata,
  output logic [15:0] pc,
  output logic [15:0] sp,
  output logic [7:0]  ccr
);

  strobes_t stb;

  subr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .busy     (busy),
    .done     (done),
    .stb      (stb)
  );

  subr_dpath #(
    .ADDR_W    (16),
    .BYTE_W    (8),
    .RESET_PC  (RESET_PC),
    .RESET_SP  (RESET_SP),
    .RESET_CCR (RESET_CCR)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqReg   (reqReg),
    .reqAbs   (reqAbs),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe),
    .pc       (pc),
    .sp       (sp),
    .ccr      (ccr)
  );

endmodule

// File: rtl/subr_seq_chk.sv
module subr_seq_chk
  import subr_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [2:0]  reqOp,
  input logic        busy,
  input logic        done,
  input logic        memWe,
  input logic [15:0] pc,
  input logic [15:0] sp,
  input logic [7:0]  ccr
);

  op_e        opSeen;
  logic [3:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opSeen  <= OP_CALL_REG;
      busyCnt <= '0;
    end else begin
      if (reqValid && !busy && reqOp <= OP_LAST_CODE) opSeen <= op_e'(reqOp);
      if (done)      busyCnt <= '0;
      else if (busy) busyCnt <= busyCnt + 4'd1;
    end
  end

  // R2
  we_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  // R2
  sp_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sp) |-> (sp == $past(sp) - 16'd2 || sp == $past(sp) + 16'd2));

  // R8
  ccr_retx_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ccr) |-> ($past(busy) && opSeen == OP_RETX));

  // R9
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));

  // R9
  pc_at_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pc) |-> $past(done));

  // R9
  state_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (32'(busyCnt) + 32'd1 == stateCount(opSeen)));

endmodule

bind subr_seq subr_seq_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqOp    (reqOp),
  .busy     (busy),
  .done     (done),
  .memWe    (memWe),
  .pc       (pc),
  .sp       (sp),
  .ccr      (ccr)
);

// File: tb/subr_seq_tb.sv
`timescale 1ns/1ps
module subr_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqOp = 3'd0;
  logic [15:0] reqReg = 16'h0;
  logic [15:0] reqAbs = 16'h0;
  logic        busy, done, memWe;
  logic [15:0] memAddr, pc, sp;
  logic [7:0]  memWdata, memRdata, ccr;

  logic [7:0]  mem [0:511];
  logic        tbWe = 1'b0;
  logic [8:0]  tbAddr = 9'h0;
  logic [7:0]  tbData = 8'h0;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  subr_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqReg(reqReg), .reqAbs(reqAbs), .busy(busy), .done(done),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .memRdata(memRdata), .pc(pc), .sp(sp), .ccr(ccr)
  );

  always @(posedge clk) begin
    if (tbWe)       mem[tbAddr] <= tbData;
    else if (memWe) mem[memAddr[8:0]] <= memWdata;
    memRdata <= mem[memAddr[8:0]];
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    tbWe = 1'b1; tbAddr = a; tbData = d;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] r, input logic [15:0] a);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqReg = r; reqAbs = a;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // Counts states from the accepting edge; injects a return request at state inj.
  task automatic waitDone(input int inj, output int cnt);
    cnt = 0;
    while (!done && cnt < 40) begin
      if (cnt == inj) begin reqValid = 1'b1; reqOp = 3'd3; end
      else reqValid = 1'b0;
      cnt++;
      @(negedge clk);
    end
    reqValid = 1'b0;
    cnt++;
    @(negedge clk);
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", 32'(busy), 32'd0);
    chk("R1", "memWe in reset", 32'(memWe), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "pc", 32'(pc), 32'h0100);
    chk("R1", "sp", 32'(sp), 32'h0200);
    chk("R1", "ccr", 32'(ccr), 32'h80);
    chk("R1", "busy/done", {30'd0, busy, done}, 32'd0);
  endtask

  task automatic tCallReg();
    int n;
    issue(3'd0, 16'h1234, 16'hFFFF);
    waitDone(-1, n);
    chk("R3", "states", n, 6);
    chk("R3", "pc", 32'(pc), 32'h1234);
    chk("R2", "sp", 32'(sp), 32'h01FE);
    chk("R2", "pushed word", {16'h0, mem[9'h1FE], mem[9'h1FF]}, 32'h0100);
    chk("R8", "ccr", 32'(ccr), 32'h80);
    chk("R9", "busy after done", 32'(busy), 32'd0);
  endtask

  task automatic tCallAbs();
    int n;
    issue(3'd1, 16'h5555, 16'hABCD);
    waitDone(-1, n);
    chk("R4", "states", n, 8);
    chk("R4", "pc", 32'(pc), 32'hABCD);
    chk("R2", "sp", 32'(sp), 32'h01FC);
    chk("R2", "pushed word", {16'h0, mem[9'h1FC], mem[9'h1FD]}, 32'h1234);
    chk("R8", "ccr", 32'(ccr), 32'h80);
  endtask

  task automatic tCallInd();
    int n;
    poke(9'h040, 8'h56);
    poke(9'h041, 8'h78);
    issue(3'd2, 16'h0000, 16'hFF40);
    waitDone(-1, n);
    chk("R5", "states", n, 8);
    chk("R5", "pc via vector 0x40", 32'(pc), 32'h5678);
    chk("R2", "sp", 32'(sp), 32'h01FA);
    chk("R2", "pushed word", {16'h0, mem[9'h1FA], mem[9'h1FB]}, 32'hABCD);
    poke(9'h0FF, 8'h9A);
    poke(9'h100, 8'hBC);
    issue(3'd2, 16'h0000, 16'h00FF);
    waitDone(-1, n);
    chk("R5", "pc via vector 0xFF", 32'(pc), 32'h9ABC);
    chk("R2", "sp second", 32'(sp), 32'h01F8);
    chk("R8", "ccr", 32'(ccr), 32'h80);
  endtask

  task automatic tRet();
    int n;
    issue(3'd3, 16'h0, 16'h0);
    waitDone(-1, n);
    chk("R6", "states", n, 8);
    chk("R6", "pc", 32'(pc), 32'h5678);
    chk("R6", "sp", 32'(sp), 32'h01FA);
    chk("R8", "ccr", 32'(ccr), 32'h80);
  endtask

  task automatic tRetx();
    int n;
    issue(3'd4, 16'h0, 16'h0);
    waitDone(-1, n);
    chk("R7", "states", n, 10);
    chk("R7", "ccr from low byte", 32'(ccr), 32'hCD);
    chk("R7", "pc from second word", 32'(pc), 32'h1234);
    chk("R7", "sp", 32'(sp), 32'h01FE);
  endtask

  task automatic tBusyIgnore();
    int n;
    issue(3'd0, 16'h2222, 16'h0);
    waitDone(2, n);
    chk("R10", "states unchanged by stray request", n, 6);
    chk("R10", "pc", 32'(pc), 32'h2222);
    chk("R10", "sp", 32'(sp), 32'h01FC);
    @(negedge clk);
    chk("R10", "no queued request", 32'(busy), 32'd0);
    chk("R8", "ccr kept", 32'(ccr), 32'hCD);
  endtask

  task automatic tBadOp();
    for (int c = 5; c < 8; c++) begin
      issue(3'(c), 16'h3333, 16'h4444);
      chk("R11", "busy", 32'(busy), 32'd0);
      @(negedge clk);
      chk("R11", "pc/sp", {pc, sp}, {16'h2222, 16'h01FC});
      chk("R11", "ccr", 32'(ccr), 32'hCD);
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tReset();
    tCallReg();
    tCallAbs();
    tCallInd();
    tRet();
    tRetx();
    tBusyIgnore();
    tBadOp();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule